// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast system clock into the nominal bit timing of a CAN node. A fixed divide-by-four stage forms the CAN system clock. A programmable prescaler then stretches that clock into the time quantum, and every bit is built from whole quanta. A bit starts with a one-quantum synchronization segment, continues with a first phase segment and ends with a second phase segment. The point where the first phase segment hands over to the second is the sample point.

The block emits four one-clock strobes: one per time quantum, one at the sample point, one at each bit boundary, and one when the information processing window ends. That window is three CAN system clock cycles long and starts at the sample point. A recessive-to-dominant edge seen on the bus resynchronizes the bit by lengthening or shortening a phase segment, within the jump width limit. A hard synchronization input restarts the bit at once. The configuration is captured only while the block is in reset or held in init, so a running bit is never disturbed by a change to the configuration inputs.

Top module: `can_bit_timer`

## Requirements
- R1: The time quantum lasts 4*(PRESC+1) system clocks. `tq_stb` pulses once per quantum, and its first pulse comes 4*(PRESC+1) clocks after init is released.
- R2: `smp_stb` pulses (1+PH1+1)*TQ clocks after a bit starts. This covers one synchronization quantum and PH1+1 first-phase quanta, with no edge seen.
- R3: With no edge seen, a bit lasts (PH1+1)+(PH2+1)+1 quanta. `bit_stb` pulses when the bit ends, and the next bit starts in the same cycle.
- R4: `ipt_stb` pulses exactly 12 system clocks (three CAN system clock cycles) after `smp_stb`. This also holds when the next sample point falls in the same cycle.
- R5: An edge in the first phase segment at quantum index q (counting from 0) lengthens that segment by min(q+1, SJW+1) quanta.
- R6: An edge in the second phase segment at quantum index q shortens it by min(PH2+1-q, SJW+1) quanta. The bit never ends before the next quantum tick.
- R7: An edge during the synchronization segment has no effect. Only the first edge in a bit adjusts timing, and a new bit accepts a fresh edge.
- R8: A `hard_sync` pulse restarts the bit. The prescaler restarts, the synchronization segment begins, and no bit strobe is issued for the bit that was cut short.
- R9: After reset all strobes are 0 and the segment code is 0. Configuration inputs are sampled only while `rst` or `init` is high.
- R10: `seg_o` encodes the current segment: 0 for synchronization, 1 for the first phase and 2 for the second phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Holds timing idle and loads configuration |
| presc_i | input | 10 | Prescaler value PRESC; quantum = PRESC+1 CAN system clocks |
| ph1_i | input | 4 | First phase length minus one, in quanta |
| ph2_i | input | 3 | Second phase length minus one, in quanta |
| sjw_i | input | 2 | Jump width minus one, in quanta |
| hard_sync | input | 1 | One-clock pulse restarting the bit |
| rx_fall | input | 1 | One-clock pulse marking a recessive-to-dominant bus edge |
| tq_stb | output | 1 | One pulse per time quantum |
| seg_o | output | 2 | Current segment code |
| smp_stb | output | 1 | Sample point strobe |
| bit_stb | output | 1 | Bit boundary strobe |
| ipt_stb | output | 1 | End of information processing window |

## Verification
Two pairs of functions can land in the same system clock cycle, and the bench aims a case at each. In the first, a bus edge arrives in the cycle of the quantum tick that would otherwise end a phase segment. The bench places `rx_fall` on the last tick of the first phase and on the first tick of the second phase. It then judges, by arithmetic, the edge numbers at which the sample and bit strobes move. In the second, the minimum configuration makes a new sample point fall in the same cycle as the end of the previous processing window. The bench checks that both strobes still appear at their computed times.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int PRESC_W = 10;
    localparam int PH1_W   = 4;
    localparam int PH2_W   = 3;
    localparam int SJW_W   = 2;
    // quantum counter must hold the longest stretched first phase
    localparam int QC_W    = PH1_W + 1;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [PH1_W-1:0]   ph1;
        logic [PH2_W-1:0]   ph2;
        logic [SJW_W-1:0]   sjw;
    } bt_cfg_t;

    function automatic logic [QC_W-1:0] qmin(input logic [QC_W-1:0] a,
                                              input logic [QC_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/can_bt_quantum.sv
module can_bt_quantum
    import can_bt_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               scl_en,
    output logic               tq_en
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0]   div_cnt;
    logic [PRESC_W-1:0] pre_cnt;

    assign scl_en = (div_cnt == DIV_W'(DIV - 1));
    assign tq_en  = scl_en && (pre_cnt == presc);

    always_ff @(posedge clk) begin
        if (restart) begin
            div_cnt <= '0;
            pre_cnt <= '0;
        end else begin
            div_cnt <= scl_en ? '0 : div_cnt + 1'b1;
            if (scl_en)
                pre_cnt <= tq_en ? '0 : pre_cnt + 1'b1;
        end
    end

    // a quantum spans at least DIV clocks, so ticks never touch
    assert_tq_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        tq_en |=> !tq_en)
        else $error("quantum ticks back to back");

endmodule

// File: rtl/can_bt_segmenter.sv
module can_bt_segmenter
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    hard_sync,
    input  logic    tq_en,
    input  logic    rx_fall,
    input  bt_cfg_t cfg,
    output seg_e    seg,
    output logic    smp_stb,
    output logic    bit_stb
);
    logic [QC_W-1:0] qc, ext_q, shr_q, ext_n, shr_n;
    logic [QC_W-1:0] ph1_len, ph2_len, jump;
    logic            used, edge_ph1, edge_ph2, ph1_end, ph2_end;

    assign ph1_len = QC_W'(cfg.ph1) + QC_W'(1);
    assign ph2_len = QC_W'(cfg.ph2) + QC_W'(1);
    assign jump    = QC_W'(cfg.sjw) + QC_W'(1);

    assign edge_ph1 = rx_fall && !used && (seg == SEG_PH1);
    assign edge_ph2 = rx_fall && !used && (seg == SEG_PH2);

    // an edge arriving on a tick already counts for that tick
    assign ext_n = edge_ph1 ? qmin(qc + QC_W'(1), jump) : ext_q;
    assign shr_n = edge_ph2 ? qmin(ph2_len - qc, jump) : shr_q;

    assign ph1_end = tq_en && (seg == SEG_PH1) && (qc + QC_W'(1) >= ph1_len + ext_n);
    assign ph2_end = tq_en && (seg == SEG_PH2) && (qc + QC_W'(1) >= ph2_len - shr_n);

    always_ff @(posedge clk) begin
        if (hold || hard_sync) begin
            seg     <= SEG_SYNC;
            qc      <= '0;
            ext_q   <= '0;
            shr_q   <= '0;
            used    <= 1'b0;
            smp_stb <= 1'b0;
            bit_stb <= 1'b0;
        end else begin
            smp_stb <= ph1_end;
            bit_stb <= ph2_end;
            ext_q   <= ext_n;
            shr_q   <= shr_n;
            used    <= used | edge_ph1 | edge_ph2;
            if (tq_en) begin
                unique case (seg)
                    SEG_SYNC: begin
                        seg   <= SEG_PH1;
                        qc    <= '0;
                        ext_q <= '0;
                        shr_q <= '0;
                        used  <= 1'b0;
                    end
                    SEG_PH1: begin
                        if (ph1_end) begin
                            seg <= SEG_PH2;
                            qc  <= '0;
                        end else begin
                            qc  <= qc + QC_W'(1);
                        end
                    end
                    default: begin
                        if (ph2_end) begin
                            seg <= SEG_SYNC;
                            qc  <= '0;
                        end else begin
                            qc  <= qc + QC_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    assert_sample_enters_ph2_R2: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> (seg == SEG_PH2) && (qc == '0))
        else $error("sample strobe outside second phase start");

    assert_bit_enters_sync_R3: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> (seg == SEG_SYNC))
        else $error("bit strobe outside sync segment");

    assert_ext_limit_R5: assert property (@(posedge clk) disable iff (rst)
        ext_q <= jump)
        else $error("phase 1 stretch beyond jump width");

    assert_shr_limit_R6: assert property (@(posedge clk) disable iff (rst)
        shr_q <= jump)
        else $error("phase 2 cut beyond jump width");

    assert_single_adjust_R7: assert property (@(posedge clk) disable iff (rst)
        !((ext_q != '0) && (shr_q != '0)))
        else $error("two adjustments in one bit");

    assert_hard_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (hard_sync && !hold) |=> (seg == SEG_SYNC) && (qc == '0) && !bit_stb)
        else $error("hard sync did not restart the bit");

endmodule

// File: rtl/can_bt_ipt.sv
module can_bt_ipt #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic scl_en,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (hold) begin
            left <= '0;
            done <= 1'b0;
        end else begin
            done <= scl_en && (left == CW'(1));
            if (start)
                left <= CW'(LEN);
            else if (scl_en && (left != '0))
                left <= left - 1'b1;
        end
    end

    assert_ipt_on_scl_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(scl_en))
        else $error("processing window ended off a CAN clock");

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int SCL_DIV = 4,
    parameter int IPT_LEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [PH1_W-1:0]   ph1_i,
    input  logic [PH2_W-1:0]   ph2_i,
    input  logic [SJW_W-1:0]   sjw_i,
    input  logic               hard_sync,
    input  logic               rx_fall,
    output logic               tq_stb,
    output logic [1:0]         seg_o,
    output logic               smp_stb,
    output logic               bit_stb,
    output logic               ipt_stb
);
    bt_cfg_t cfg_q;
    seg_e    seg;
    logic    hold, scl_en, tq_en;

    assign hold = rst || init;

    always_ff @(posedge clk) begin
        if (hold)
            cfg_q <= '{presc: presc_i, ph1: ph1_i, ph2: ph2_i, sjw: sjw_i};
        if (hold || hard_sync)
            tq_stb <= 1'b0;
        else
            tq_stb <= tq_en;
    end

    can_bt_quantum #(.DIV(SCL_DIV)) u_quantum (
        .clk     (clk),
        .rst     (rst),
        .restart (hold || hard_sync),
        .presc   (cfg_q.presc),
        .scl_en  (scl_en),
        .tq_en   (tq_en)
    );

    can_bt_segmenter u_seg (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .hard_sync (hard_sync),
        .tq_en     (tq_en),
        .rx_fall   (rx_fall),
        .cfg       (cfg_q),
        .seg       (seg),
        .smp_stb   (smp_stb),
        .bit_stb   (bit_stb)
    );

    can_bt_ipt #(.LEN(IPT_LEN)) u_ipt (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .scl_en (scl_en),
        .start  (smp_stb),
        .done   (ipt_stb)
    );

    assign seg_o = seg;

    assert_seg_code_R10: assert property (@(posedge clk) disable iff (rst)
        seg_o != 2'd3)
        else $error("illegal segment code");

    assert_config_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (!init && !$past(init)) |-> $stable(cfg_q))
        else $error("configuration changed while running");

endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init = 1'b0;
    logic [9:0] presc_i = '0;
    logic [3:0] ph1_i = '0;
    logic [2:0] ph2_i = '0;
    logic [1:0] sjw_i = '0;
    logic       hard_sync = 1'b0;
    logic       rx_fall = 1'b0;
    logic       tq_stb, smp_stb, bit_stb, ipt_stb;
    logic [1:0] seg_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int q1, q2, s1, s2, b1, i1, seg_t, seg_s, seg_b;

    always #5 clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst(rst), .init(init),
        .presc_i(presc_i), .ph1_i(ph1_i), .ph2_i(ph2_i), .sjw_i(sjw_i),
        .hard_sync(hard_sync), .rx_fall(rx_fall),
        .tq_stb(tq_stb), .seg_o(seg_o), .smp_stb(smp_stb),
        .bit_stb(bit_stb), .ipt_stb(ipt_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // edges are counted from the first rising edge with init low (edge 1);
    // rx/hs/chg name the edge whose preceding cycle carries the stimulus
    task automatic run_cfg(input int b, input int t1, input int t2, input int s,
                           input int rx1, input int rx2, input int hs,
                           input int chg, input int n);
        int tq;
        tq = 4 * (b + 1);
        @(negedge clk);
        init = 1'b1;
        presc_i = 10'(b); ph1_i = 4'(t1); ph2_i = 3'(t2); sjw_i = 2'(s);
        rx_fall = 1'b0; hard_sync = 1'b0;
        @(negedge clk);
        @(negedge clk);
        init = 1'b0;
        rx_fall = (rx1 == 1) || (rx2 == 1);
        hard_sync = (hs == 1);
        q1 = -1; q2 = -1; s1 = -1; s2 = -1; b1 = -1; i1 = -1;
        seg_t = -1; seg_s = -1; seg_b = -1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (tq_stb) begin
                if (q1 < 0) q1 = k; else if (q2 < 0) q2 = k;
            end
            if (smp_stb) begin
                if (s1 < 0) begin s1 = k; seg_s = int'(seg_o); end
                else if (s2 < 0) s2 = k;
            end
            if (bit_stb && b1 < 0) begin b1 = k; seg_b = int'(seg_o); end
            if (ipt_stb && i1 < 0) i1 = k;
            if (k == tq) seg_t = int'(seg_o);
            rx_fall = (k + 1 == rx1) || (k + 1 == rx2);
            hard_sync = (k + 1 == hs);
            if (k + 1 == chg) begin
                presc_i = 10'd3; ph1_i = 4'd9; ph2_i = 3'd6; sjw_i = 2'd3;
            end
        end
        rx_fall = 1'b0;
        hard_sync = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset tq_stb", int'(tq_stb), 0);
        chk("R9 reset smp_stb", int'(smp_stb), 0);
        chk("R9 reset bit_stb", int'(bit_stb), 0);
        chk("R9 reset ipt_stb", int'(ipt_stb), 0);
        chk("R9 reset seg_o", int'(seg_o), 0);
        rst = 1'b0;

        // sweep: prescaler 0..2, phase 1 in {1,3,7,15}, phase 2 all values
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 4; i++) begin
                for (int t2 = 0; t2 < 8; t2++) begin
                    int t1, tq, bt;
                    t1 = (2 << i) - 1;
                    tq = 4 * (b + 1);
                    bt = tq * (t1 + t2 + 3);
                    run_cfg(b, t1, t2, 0, 0, 0, 0, 0, 2 * bt + 20);
                    chk("R1 first quantum", q1, tq);
                    chk("R1 quantum period", q2 - q1, tq);
                    chk("R2 sample point", s1, tq * (t1 + 2));
                    chk("R3 bit length", b1, bt);
                    chk("R3 next sample", s2, bt + tq * (t1 + 2));
                    chk("R4 window end", i1, s1 + 12);
                    chk("R10 seg after sync", seg_t, 1);
                    chk("R10 seg after sample", seg_s, 2);
                    chk("R10 seg after bit", seg_b, 0);
                end
            end
        end

        // minimum bit: new sample coincides with the previous window end
        run_cfg(0, 0, 0, 0, 0, 0, 0, 0, 40);
        chk("R4 min sample", s1, 8);
        chk("R4 min window end", i1, 20);
        chk("R4 min second sample", s2, 20);

        // fixed config for edges: quantum 4 clocks, sample 28, bit 44
        run_cfg(0, 5, 3, 1, 6, 0, 0, 0, 100);
        chk("R5 early phase1 edge", s1, 32);
        chk("R5 early phase1 bit", b1, 48);
        run_cfg(0, 5, 3, 1, 10, 0, 0, 0, 100);
        chk("R5 clamped phase1 edge", s1, 36);
        chk("R5 clamped phase1 bit", b1, 52);
        run_cfg(0, 5, 3, 1, 28, 0, 0, 0, 100);
        chk("R5 edge on ending tick", s1, 36);
        run_cfg(0, 5, 3, 1, 2, 0, 0, 0, 100);
        chk("R7 edge in sync ignored", s1, 28);
        chk("R7 edge in sync ignored bit", b1, 44);
        run_cfg(0, 5, 3, 1, 6, 18, 0, 0, 100);
        chk("R7 second edge ignored", s1, 32);
        chk("R7 second edge ignored bit", b1, 48);
        run_cfg(0, 5, 3, 1, 6, 54, 0, 0, 100);
        chk("R7 new bit accepts edge", s2, 80);
        run_cfg(0, 5, 3, 1, 34, 0, 0, 0, 100);
        chk("R6 phase2 cut", b1, 36);
        chk("R6 phase2 cut sample kept", s1, 28);
        run_cfg(0, 5, 3, 1, 38, 0, 0, 0, 100);
        chk("R6 phase2 cut to next tick", b1, 40);
        run_cfg(0, 5, 3, 0, 34, 0, 0, 0, 100);
        chk("R6 phase2 cut clamped by jump", b1, 40);
        run_cfg(0, 5, 3, 1, 32, 0, 0, 0, 100);
        chk("R6 edge on first phase2 tick", b1, 36);

        run_cfg(0, 5, 3, 1, 0, 0, 40, 0, 100);
        chk("R8 sample before hard sync", s1, 28);
        chk("R8 sample after hard sync", s2, 68);
        chk("R8 bit after hard sync", b1, 84);

        run_cfg(0, 5, 3, 1, 0, 0, 0, 10, 100);
        chk("R9 config frozen sample", s1, 28);
        chk("R9 config frozen bit", b1, 44);
        chk("R9 config frozen next sample", s2, 72);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule